// File: doc/BRIEF.md
# Serial EEPROM Device-Side Command Engine

This block plays the memory side of a byte-wide serial EEPROM on an SPI mode 0 bus. A transfer opens when chip select falls. It starts with an 8-bit opcode, and some commands then take a 16-bit address. Five commands are decoded: set the write latch, clear the write latch, report status, read, and page write. The storage is an internal byte array whose size comes from a parameter.

Page-write data goes into a 128-byte page buffer first. The buffer is copied into the array only when chip select rises cleanly on a byte boundary. A countdown of system-clock cycles then models the programming time. While that countdown runs, the engine accepts the status command and nothing else.

The SPI pins are oversampled by a faster system clock `clk`. Each pin passes through a parameterised synchronizer, and the SCK edges are detected in the `clk` domain. SO comes out as a data bit plus an output enable, so the pad can be driven or left in high impedance.

Top module: `eeprom_spi_slave`

## Requirements
- R1: After reset the status byte reads 0x00, the output enable `so_en` is low, and every array byte reads 0xFF.
- R2: Opcode 0x03, followed by a 16-bit address sent MSB first, starts a read. Once the address is complete, SI is ignored. Each addressed byte is shifted out MSB first, with each bit presented after a falling SCK edge.
- R3: During a read, the array address advances by one after each byte and wraps from the top of the array to 0. Address bits at and above `ADDR_W` are ignored.
- R4: Opcode 0x06 sets the write latch and opcode 0x04 clears it. Opcode 0x05 returns the status byte repeatedly, with bit 0 = busy and bit 1 = write latch.
- R5: A page write (opcode 0x02) sent while the write latch is clear changes nothing and starts no busy period.
- R6: During a page write, the low 7 address bits advance after each data byte and wrap within the 128-byte page, while the upper bits stay fixed. A later byte sent to the same offset replaces the earlier one. Offsets that received no byte keep their old contents.
- R7: A page write is committed only when chip select rises after a whole, nonzero number of data bytes. A rise in the middle of a byte, or a rise straight after the address, leaves the array and the busy bit unchanged.
- R8: A commit sets status bit 0 for `BUSY_CYCLES` clock cycles. When this busy period ends, the write latch clears by itself.
- R9: While busy, every opcode except 0x05 is ignored for the rest of its transfer: reads drive nothing, and write-latch commands have no effect.
- R10: An unknown opcode, or 0x01, causes the rest of the transfer to be ignored. SO stays undriven and the status is unchanged.
- R11: `so_en` is low whenever chip select is high, and also during opcode and address bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, mode 0 |
| si | input | 1 | Serial data into the device |
| so | output | 1 | Serial data out of the device |
| so_en | output | 1 | High when the SO pad should be driven |

## Verification
The bench builds the engine with `ADDR_W = 8` (a 256-byte array holding two pages) and `BUSY_CYCLES = 2000`. With the small array, a single read of 258 bytes sweeps every location and crosses the wrap to address 0, and each byte is compared with a model held in the bench. The busy period is long enough that a status poll, a blocked read and a blocked write-latch command all fit inside it. An overlong page write overwrites part of its own page. Aborted and empty writes can be shown to leave both pages untouched.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_OPC,
        S_ADR,
        S_RD,
        S_STAT,
        S_WR,
        S_SKIP
    } phase_t;

    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_WRSR  = 8'h01;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRITE = 8'h02;

    typedef struct packed {
        logic [5:0] rsvd;
        logic       wel;
        logic       busy;
    } status_t;

    function automatic status_t make_status(input logic wel, input logic busy);
        status_t s;
        s.rsvd = '0;
        s.wel  = wel;
        s.busy = busy;
        return s;
    endfunction

endpackage

// File: rtl/eeprom_pin_sync.sv
module eeprom_pin_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic lvl,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= {(STAGES+1){RST_VAL}};
        else     sh <= {sh[STAGES-1:0], pin};
    end

    assign lvl  = sh[STAGES-1];
    assign rise = sh[STAGES-1] & ~sh[STAGES];
    assign fall = ~sh[STAGES-1] & sh[STAGES];
endmodule

// File: rtl/eeprom_busy_timer.sv
module eeprom_busy_timer #(
    parameter int CYCLES = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= CW'(CYCLES - 1);
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end
    end

    assign done = busy && (cnt == '0);
endmodule

// File: rtl/eeprom_page_buf.sv
module eeprom_page_buf #(
    parameter int PAGE_W = 7
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        clr,
    input  logic [PAGE_W-1:0]           start_idx,
    input  logic                        wr_en,
    input  logic [7:0]                  wr_data,
    output logic [(1<<PAGE_W)-1:0][7:0] data,
    output logic [(1<<PAGE_W)-1:0]      mask,
    output logic                        any
);
    logic [PAGE_W-1:0] ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            data <= '0;
            mask <= '0;
            ptr  <= '0;
            any  <= 1'b0;
        end else if (clr) begin
            mask <= '0;
            ptr  <= start_idx;
            any  <= 1'b0;
        end else if (wr_en) begin
            data[ptr] <= wr_data;
            mask[ptr] <= 1'b1;
            ptr       <= ptr + 1'b1;
            any       <= 1'b1;
        end
    end
endmodule

// File: rtl/eeprom_spi_slave.sv
module eeprom_spi_slave
    import eeprom_pkg::*;
#(
    parameter int ADDR_W      = 9,
    parameter int BUSY_CYCLES = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    output logic so,
    output logic so_en
);
    localparam int PAGE_W = 7;
    localparam int PAGE   = 1 << PAGE_W;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int PG_W   = ADDR_W - PAGE_W;

    logic cs_lvl, cs_rise, cs_fall;
    logic sck_lvl, sck_rise, sck_fall;
    logic si_lvl, si_r, si_f;

    eeprom_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs (
        .clk(clk), .rst(rst), .pin(cs_n), .lvl(cs_lvl), .rise(cs_rise), .fall(cs_fall));
    eeprom_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck (
        .clk(clk), .rst(rst), .pin(sck), .lvl(sck_lvl), .rise(sck_rise), .fall(sck_fall));
    eeprom_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_si (
        .clk(clk), .rst(rst), .pin(si), .lvl(si_lvl), .rise(si_r), .fall(si_f));

    phase_t            st;
    logic [2:0]        bitcnt;
    logic [6:0]        shreg;
    logic              adr_hi;
    logic [7:0]        adr_h;
    logic              is_wr;
    logic [ADDR_W-1:0] rd_ptr;
    logic [PG_W-1:0]   wr_page;
    logic [7:0]        obyte;
    logic              so_q, en_q;
    logic              wel;
    logic              busy, busy_done;
    logic [7:0]        mem [DEPTH];

    logic [7:0]          byte_in;
    logic                sck_act, byte_done, op_done;
    logic [ADDR_W-1:0]   full_adr;
    status_t             stat;
    logic                pb_clr, pb_wr, pb_any;
    logic [PAGE-1:0][7:0] pb_data;
    logic [PAGE-1:0]     pb_mask;
    logic                commit;

    assign byte_in   = {shreg, si_lvl};
    assign sck_act   = sck_rise && !cs_lvl;
    assign byte_done = sck_act && (bitcnt == 3'd7);
    assign op_done   = byte_done && (st == S_OPC) && !busy;
    assign full_adr  = ADDR_W'({adr_h, byte_in});
    assign stat      = make_status(wel, busy);
    assign pb_clr    = byte_done && (st == S_ADR) && adr_hi && is_wr;
    assign pb_wr     = byte_done && (st == S_WR);
    assign commit    = cs_rise && (st == S_WR) && (bitcnt == 3'd0) && pb_any;

    eeprom_page_buf #(.PAGE_W(PAGE_W)) u_pbuf (
        .clk(clk), .rst(rst), .clr(pb_clr), .start_idx(full_adr[PAGE_W-1:0]),
        .wr_en(pb_wr), .wr_data(byte_in), .data(pb_data), .mask(pb_mask), .any(pb_any));

    eeprom_busy_timer #(.CYCLES(BUSY_CYCLES)) u_busy (
        .clk(clk), .rst(rst), .start(commit), .busy(busy), .done(busy_done));

    // Command sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_IDLE;
            bitcnt  <= '0;
            shreg   <= '0;
            adr_hi  <= 1'b0;
            adr_h   <= '0;
            is_wr   <= 1'b0;
            rd_ptr  <= '0;
            wr_page <= '0;
            obyte   <= '0;
        end else if (cs_fall) begin
            st     <= S_OPC;
            bitcnt <= '0;
        end else if (cs_lvl) begin
            st     <= S_IDLE;
            bitcnt <= '0;
        end else if (sck_rise) begin
            bitcnt <= bitcnt + 1'b1;
            shreg  <= byte_in[6:0];
            if (bitcnt == 3'd7) begin
                case (st)
                    S_OPC: begin
                        if (busy) begin
                            st    <= (byte_in == OP_RDSR) ? S_STAT : S_SKIP;
                            obyte <= stat;
                        end else begin
                            adr_hi <= 1'b0;
                            case (byte_in)
                                OP_RDSR:  begin st <= S_STAT; obyte <= stat; end
                                OP_READ:  begin st <= S_ADR; is_wr <= 1'b0; end
                                OP_WRITE: begin
                                    st    <= wel ? S_ADR : S_SKIP;
                                    is_wr <= 1'b1;
                                end
                                default:  st <= S_SKIP;
                            endcase
                        end
                    end
                    S_ADR: begin
                        if (!adr_hi) begin
                            adr_h  <= byte_in;
                            adr_hi <= 1'b1;
                        end else if (is_wr) begin
                            st      <= S_WR;
                            wr_page <= full_adr[ADDR_W-1:PAGE_W];
                        end else begin
                            st     <= S_RD;
                            obyte  <= mem[full_adr];
                            rd_ptr <= full_adr + 1'b1;
                        end
                    end
                    S_RD: begin
                        obyte  <= mem[rd_ptr];
                        rd_ptr <= rd_ptr + 1'b1;
                    end
                    S_STAT:  obyte <= stat;
                    default: ;
                endcase
            end
        end
    end

    // Write latch: clearing at end of programming wins
    always_ff @(posedge clk) begin
        if (rst)                                wel <= 1'b0;
        else if (busy_done)                     wel <= 1'b0;
        else if (op_done && byte_in == OP_WREN) wel <= 1'b1;
        else if (op_done && byte_in == OP_WRDI) wel <= 1'b0;
    end

    // Serial output, updated on falling SCK
    always_ff @(posedge clk) begin
        if (rst || cs_lvl) begin
            so_q <= 1'b0;
            en_q <= 1'b0;
        end else if (sck_fall) begin
            if (st == S_RD || st == S_STAT) begin
                so_q <= obyte[~bitcnt];
                en_q <= 1'b1;
            end else begin
                en_q <= 1'b0;
            end
        end
    end

    assign so    = so_q;
    assign so_en = en_q && !cs_lvl;

    // Array with page commit
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (commit) begin
            for (int i = 0; i < PAGE; i++)
                if (pb_mask[i]) mem[{wr_page, PAGE_W'(i)}] <= pb_data[i];
        end
    end
endmodule

// File: rtl/eeprom_spi_slave_chk.sv
module eeprom_spi_slave_chk
    import eeprom_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   so_en,
    input phase_t st,
    input logic   busy,
    input logic   wel,
    input logic   commit
);
    p_commit_needs_wel_r5: assert property (@(posedge clk) disable iff (rst)
        commit |-> wel);

    p_commit_starts_busy_r8: assert property (@(posedge clk) disable iff (rst)
        commit |=> busy);

    p_wel_cleared_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !wel);

    p_no_commit_busy_r9: assert property (@(posedge clk) disable iff (rst)
        busy |-> !commit);

    p_busy_blocks_r9: assert property (@(posedge clk) disable iff (rst)
        busy |-> !(st == S_RD || st == S_WR || st == S_ADR));

    p_so_only_sending_r11: assert property (@(posedge clk) disable iff (rst)
        so_en |-> (st == S_RD || st == S_STAT));
endmodule

bind eeprom_spi_slave eeprom_spi_slave_chk u_chk (
    .clk(clk), .rst(rst), .so_en(so_en), .st(st),
    .busy(busy), .wel(wel), .commit(commit));

// File: tb/eeprom_spi_slave_test.sv
module eeprom_spi_slave_test;
    localparam int CLK_P  = 10;
    localparam int HALF   = 6;
    localparam int AW     = 8;
    localparam int NBYTES = 1 << AW;
    localparam int BUSY   = 2000;

    logic clk = 0, rst = 1, cs_n = 1, sck = 0, si = 0;
    logic so, so_en;
    int checks = 0, errors = 0;
    logic [7:0] model [NBYTES];

    eeprom_spi_slave #(.ADDR_W(AW), .BUSY_CYCLES(BUSY)) uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si), .so(so), .so_en(so_en));

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic cs_lo();
        @(negedge clk); cs_n = 0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic cs_hi();
        repeat (HALF) @(negedge clk); cs_n = 1;
        repeat (HALF*2) @(negedge clk);
    endtask

    task automatic spi_bits(input logic [7:0] tx, input int n, output logic [7:0] rx, output int en_cnt);
        rx = '0; en_cnt = 0;
        for (int i = 7; i > 7 - n; i--) begin
            si = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = so;
            if (so_en) en_cnt++;
            sck = 1;
            repeat (HALF) @(negedge clk);
            sck = 0;
        end
    endtask

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx, output int en_cnt);
        spi_bits(tx, 8, rx, en_cnt);
    endtask

    task automatic status(output logic [7:0] s);
        logic [7:0] r; int e;
        cs_lo(); spi_byte(8'h05, r, e); spi_byte(8'h00, s, e); cs_hi();
    endtask

    task automatic one_op(input logic [7:0] op);
        logic [7:0] r; int e;
        cs_lo(); spi_byte(op, r, e); cs_hi();
    endtask

    // Read n bytes and compare against the model; hdr_en counts drive during header
    task automatic read_cmp(input logic [15:0] adr, input int n, input string req);
        logic [7:0] r; int e, hdr;
        hdr = 0;
        cs_lo();
        spi_byte(8'h03, r, e); hdr += e;
        spi_byte(adr[15:8], r, e); hdr += e;
        spi_byte(adr[7:0], r, e); hdr += e;
        check("R11 header undriven", hdr, 0);
        for (int k = 0; k < n; k++) begin
            spi_byte(8'hC3, r, e);
            check(req, {e[7:0], r}, {8'd8, model[(adr + k) % NBYTES]});
        end
        cs_hi();
    endtask

    task automatic wait_idle();
        repeat (BUSY + 50) @(negedge clk);
    endtask

    task automatic page_write(input logic [15:0] adr, input int n, input int seed);
        logic [7:0] r; int e, base, off;
        cs_lo();
        spi_byte(8'h02, r, e); spi_byte(adr[15:8], r, e); spi_byte(adr[7:0], r, e);
        base = adr[AW-1:7] * 128;
        for (int k = 0; k < n; k++) begin
            off = (adr[6:0] + k) % 128;
            spi_byte(8'((k * 37 + seed) ^ 8'h5A), r, e);
            model[base + off] = 8'((k * 37 + seed) ^ 8'h5A);
        end
        cs_hi();
    endtask

    initial begin
        logic [7:0] s, r;
        int e, tot;
        for (int i = 0; i < NBYTES; i++) model[i] = 8'hFF;
        repeat (4) @(negedge clk);
        rst = 0;
        repeat (4) @(negedge clk);

        check("R1 so_en after reset", so_en, 0);
        check("R11 so_en with cs high", so_en, 0);
        status(s);
        check("R1 status after reset", s, 8'h00);
        read_cmp(16'h0000, 4, "R1 erased array");

        // R5: write without latch
        cs_lo();
        spi_byte(8'h02, r, e); spi_byte(8'h00, r, e); spi_byte(8'h10, r, e);
        spi_byte(8'hAA, r, e); spi_byte(8'hBB, r, e);
        cs_hi();
        status(s);
        check("R5 no busy without latch", s, 8'h00);
        read_cmp(16'h0010, 2, "R5 array unchanged");

        // R4 latch set/clear
        one_op(8'h06); status(s); check("R4 latch set", s, 8'h02);
        one_op(8'h04); status(s); check("R4 latch cleared", s, 8'h00);

        // R4 repeated status bytes
        one_op(8'h06);
        cs_lo(); spi_byte(8'h05, r, e);
        for (int k = 0; k < 3; k++) begin
            spi_byte(8'h00, r, e);
            check("R4 repeated status", {e[7:0], r}, {8'd8, 8'h02});
        end
        cs_hi();

        // Full page 0 write, upper address bits ignored (R3)
        page_write(16'h3300, 128, 3);
        status(s);
        check("R8 busy and latch during programming", s, 8'h03);
        cs_lo();
        spi_byte(8'h03, r, e); spi_byte(8'h00, r, e); spi_byte(8'h00, r, e);
        tot = 0;
        for (int k = 0; k < 2; k++) begin spi_byte(8'h00, r, e); tot += e; end
        cs_hi();
        check("R9 read blocked while busy", tot, 0);
        one_op(8'h04);
        status(s);
        check("R9 WRDI ignored while busy", s, 8'h03);
        wait_idle();
        status(s);
        check("R8 busy done and latch auto-cleared", s, 8'h00);

        // R6 overlong page write wraps in page 1
        one_op(8'h06);
        page_write(16'h00F0, 144, 11);
        wait_idle();
        status(s);
        check("R8 latch cleared after second write", s, 8'h00);

        // R7 aborted write mid-byte
        one_op(8'h06);
        cs_lo();
        spi_byte(8'h02, r, e); spi_byte(8'h00, r, e); spi_byte(8'h05, r, e);
        spi_byte(8'h11, r, e); spi_bits(8'h22, 3, r, e);
        cs_hi();
        status(s);
        check("R7 mid-byte rise no commit", s, 8'h02);

        // R7 empty write after address
        cs_lo();
        spi_byte(8'h02, r, e); spi_byte(8'h00, r, e); spi_byte(8'h20, r, e);
        cs_hi();
        status(s);
        check("R7 empty write no commit", s, 8'h02);

        // R10 unknown opcode and status-write opcode
        cs_lo(); spi_byte(8'hAB, r, e); tot = e;
        for (int k = 0; k < 3; k++) begin spi_byte(8'h03, r, e); tot += e; end
        cs_hi();
        check("R10 unknown opcode undriven", tot, 0);
        cs_lo(); spi_byte(8'h01, r, e); spi_byte(8'h00, r, e); tot = e; cs_hi();
        check("R10 WRSR undriven", tot, 0);
        status(s);
        check("R10 status unchanged", s, 8'h02);

        // R6 partial write keeps neighbours
        page_write(16'h0041, 2, 99);
        wait_idle();

        // R2/R3/R6/R7 full sweep with wrap; upper bits 0xFF ignored
        read_cmp(16'hFF80, NBYTES + 2, "R2 R3 R6 R7 sweep");

        check("R11 so_en idle at end", so_en, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule